// File: doc/BRIEF.md
# Bit-Addressed Serial I/O Port

This block is the peripheral end of a bit-serial I/O bus. A processor places a 12-bit bit address on its address lines (A3 through A14) and moves exactly one bit per bus cycle. A write puts the data bit on a single serial-out line and pulses a strobe. The block decodes the address, picks one latch from its bank of output bits, and loads the data bit into it. A read needs only the address lines. The block decodes the address and drives the matching input pin onto a single serial-in line that goes back to the processor.

The port answers only inside a window of `NBITS` consecutive bit addresses that starts at the parameter `BASE`. Addresses outside the window leave the output bank unchanged and hold the serial-in line at 0. The processor moves multi-bit and word quantities as runs of single-bit cycles at consecutive addresses, so the block itself only ever handles one bit at a time. The strobe is a synchronous one-cycle pulse in the system clock domain. Reset is synchronous and active high.

Top module: `sbio_port`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `pin_out` becomes 0 at that edge, whatever the other inputs are.
- R2: When `wr_stb` is high at a rising edge and `bit_addr` is in the window `[BASE, BASE+NBITS)`, the value of `sout` appears on `pin_out[bit_addr-BASE]` after that edge.
- R3: A strobed write changes no `pin_out` bit other than the one at index `bit_addr-BASE`.
- R4: A strobe whose `bit_addr` lies outside the window leaves all of `pin_out` unchanged. This includes `BASE-1`, `BASE+NBITS`, and an address that differs from an in-window address only in its top bit.
- R5: In a cycle where `wr_stb` is low, `pin_out` keeps its value even while `sout` and `bit_addr` change.
- R6: When `bit_addr` is inside the window, `sin` equals `pin_in[bit_addr-BASE]` in the same cycle, with no register in the path. This holds up to and including the last address, `BASE+NBITS-1`.
- R7: When `bit_addr` is outside the window, `sin` is 0 even if every `pin_in` bit is 1.
- R8: A multi-bit transfer done as single-bit cycles at consecutive addresses sets or clears each addressed latch in turn, one bit per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_addr | input | 12 | Bit address taken from address lines A3..A14 |
| sout | input | 1 | Serial data bit from the processor for writes |
| wr_stb | input | 1 | One-cycle write strobe |
| sin | output | 1 | Serial data bit back to the processor for reads |
| pin_in | input | NBITS | Input bits that can be read |
| pin_out | output | NBITS | Output latch bank |

## Verification
Assertions check the following on every clock:
- the write select is one-hot or empty, and empty outside the window;
- a cycle with no write enable leaves the latch bank stable;
- a write changes at most one latch, and that latch takes the strobed data;
- `sin` is low whenever the address falls below or beyond the window.

Some behaviours can only be shown by the bench scenarios:
- mapping each address to the correct physical bit, which the bench does with a walking one through the whole bank;
- correct read values for a known input pattern;
- the exact window edges;
- reset clearing a bank that has been loaded.

// File: rtl/sbio_pkg.sv
package sbio_pkg;
  localparam int ADDR_W = 12;

  typedef logic [ADDR_W-1:0] baddr_t;

  // offset of a bit address from the window base (wraps below base)
  function automatic baddr_t bit_offset(input baddr_t a, input baddr_t base);
    return a - base;
  endfunction

  // an offset is a hit when it lands inside the window of n bits
  function automatic logic in_window(input baddr_t off, input int unsigned n);
    return {{(32-ADDR_W){1'b0}}, off} < n;
  endfunction
endpackage

// File: rtl/sbio_decode.sv
module sbio_decode #(
  parameter sbio_pkg::baddr_t BASE  = 12'h080,
  parameter int unsigned      NBITS = 32,
  localparam int              IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  sbio_pkg::baddr_t    bit_addr,
  input  logic                wr_stb,
  output logic                hit,
  output logic                wr_en,
  output logic [IDX_W-1:0]    idx,
  output logic [NBITS-1:0]    sel
);
  sbio_pkg::baddr_t off;

  assign off   = sbio_pkg::bit_offset(bit_addr, BASE);
  assign hit   = sbio_pkg::in_window(off, NBITS);
  assign idx   = off[IDX_W-1:0];
  assign wr_en = wr_stb & hit;

  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel[i] = wr_en && (idx == IDX_W'(i));
  end

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  // R4
  sel_quiet_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (sel == '0));
endmodule

// File: rtl/sbio_out_bank.sv
module sbio_out_bank #(
  parameter int unsigned NBITS = 32,
  localparam int         IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] sel,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             d,
  output logic [NBITS-1:0] q
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (sel[i]) q[i] <= d;
    end
  end

  // R2
  latch_takes_data_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (q[$past(idx)] == $past(d)));

  // R3
  single_bit_change_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ($countones(q ^ $past(q)) <= 1));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/sbio_in_mux.sv
module sbio_in_mux #(
  parameter int unsigned NBITS = 32,
  localparam int         IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [NBITS-1:0] pin_in,
  output logic             sin
);
  always_comb begin
    sin = 1'b0;
    if (hit) sin = pin_in[idx];
  end
endmodule

// File: rtl/sbio_port.sv
module sbio_port #(
  parameter sbio_pkg::baddr_t BASE  = 12'h080,
  parameter int unsigned      NBITS = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [sbio_pkg::ADDR_W-1:0] bit_addr,
  input  logic                      sout,
  input  logic                      wr_stb,
  output logic                      sin,
  input  logic [NBITS-1:0]          pin_in,
  output logic [NBITS-1:0]          pin_out
);
  localparam int          IDX_W   = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int unsigned WIN_END = 32'(BASE) + NBITS;

  logic             hit;
  logic             wr_en;
  logic [IDX_W-1:0] idx;
  logic [NBITS-1:0] sel;

  sbio_decode #(.BASE(BASE), .NBITS(NBITS)) u_decode (
    .clk(clk), .rst(rst), .bit_addr(bit_addr), .wr_stb(wr_stb),
    .hit(hit), .wr_en(wr_en), .idx(idx), .sel(sel)
  );

  sbio_out_bank #(.NBITS(NBITS)) u_bank (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .idx(idx),
    .d(sout), .q(pin_out)
  );

  sbio_in_mux #(.NBITS(NBITS)) u_mux (
    .hit(hit), .idx(idx), .pin_in(pin_in), .sin(sin)
  );

  // R7
  below_window_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_addr < BASE) |-> !sin);

  // R7
  above_window_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ({20'b0, bit_addr} >= WIN_END) |-> !sin);
endmodule

// File: tb/sbio_port_tb.sv
module sbio_port_tb;
  localparam logic [11:0] BASE = 12'h080;
  localparam int          NB   = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   bit_addr = '0;
  logic          sout = 1'b0;
  logic          wr_stb = 1'b0;
  logic          sin;
  logic [NB-1:0] pin_in = '0;
  logic [NB-1:0] pin_out;

  always #10 clk = ~clk;

  sbio_port #(.BASE(BASE), .NBITS(NB)) u_dut (
    .clk(clk), .rst(rst), .bit_addr(bit_addr), .sout(sout),
    .wr_stb(wr_stb), .sin(sin), .pin_in(pin_in), .pin_out(pin_out)
  );

  typedef struct {
    string         tag;
    logic [NB-1:0] eo;
    logic          es;
    bit            cs;
  } item_t;

  item_t         sb[$];
  logic [NB-1:0] model = '0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  function automatic bit inwin(input logic [11:0] a);
    return (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE) + NB);
  endfunction

  task automatic push(input string tag, input logic es, input bit cs);
    item_t it;
    it.tag = tag; it.eo = model; it.es = es; it.cs = cs;
    sb.push_back(it);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; wr_stb = 1'b0; sout = 1'b1;
    model = '0;
    push(tag, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic v, input string tag);
    @(negedge clk);
    bit_addr = a; sout = v; wr_stb = 1'b1;
    if (inwin(a)) model[int'(a) - int'(BASE)] = v;
    push(tag, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic e;
    @(negedge clk);
    bit_addr = a; wr_stb = 1'b0; sout = ~sout;
    e = inwin(a) ? pin_in[int'(a) - int'(BASE)] : 1'b0;
    push(tag, e, 1'b1);
  endtask

  // scoreboard monitor: compares a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (pin_out !== it.eo) begin
          errors++;
          $display("FAIL %s: pin_out=%h expected %h", it.tag, pin_out, it.eo);
        end
        if (it.cs) begin
          checks++;
          if (sin !== it.es) begin
            errors++;
            $display("FAIL %s: sin=%b expected %b", it.tag, sin, it.es);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset("R1 initial");

    // R2 R3 walking one through every latch
    for (int i = 0; i < NB; i++) begin
      wr(BASE + 12'(i), 1'b1, "R2 walk set");
      wr(BASE + 12'(i), 1'b0, "R3 walk clear");
    end

    // R8 consecutive single-bit cycles build a word
    for (int i = 0; i < 16; i++)
      wr(BASE + 12'(i), 1'(16'hC35A >> i), "R8 word write");

    // R4 strobes outside the window
    wr(BASE - 12'd1, 1'b1, "R4 below base");
    wr(BASE + 12'(NB), 1'b1, "R4 past end");
    wr(BASE ^ 12'h800, 1'b1, "R4 top bit alias");
    wr(BASE + 12'(NB - 1), 1'b1, "R2 last bit");

    // R5 no strobe, moving address and data
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr_stb = 1'b0; sout = 1'(i); bit_addr = BASE + 12'(i);
      push("R5 no strobe", 1'b0, 1'b0);
    end

    // R6 read back a known input pattern
    pin_in = 32'hA5C3_1E69;
    for (int i = 0; i < NB; i++)
      rd(BASE + 12'(i), "R6 read bit");

    // R7 reads outside the window with all inputs high
    pin_in = '1;
    rd(BASE - 12'd1, "R7 below base");
    rd(BASE + 12'(NB), "R7 past end");
    rd(12'hFFF, "R7 top address");
    rd(BASE + 12'(NB - 1), "R6 last bit");

    do_reset("R1 clears loaded bank");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule